// File: doc/BRIEF.md
# Soft-Decision Viterbi Decoder Accelerator

This block is a command-driven Viterbi decoding datapath that sits next to a processor pipeline. It decodes a rate-1/3 convolutional code with constraint length 7, which gives 64 trellis states. For each decoded bit the caller supplies three signed 8-bit soft values packed into one 32-bit word. The block keeps the 64 path metrics internally. The survivor decisions are handed back to the caller, which stores them itself.

One trellis stage takes two consecutive commands. The first consumes the soft sample and resolves the lower 32 states. The second takes no sample and resolves the upper 32 states. Each command returns a 32-bit word of decision bits. Once a frame has been fed in, the caller walks backwards through its stored decision words, one stage per traceback command. Each traceback command yields one decoded bit. On every 32nd traceback command the block returns a packed 32-bit word of decoded data. A separate clear command zeroes all path metrics and restarts traceback between frames.

Top module: `vit_accel`

## Requirements
- R1: Soft component j (j = 0, 1, 2) sits in bits [8j+7:8j] of `cmd_sample` as a signed byte, where a positive value means coded bit 1. Coded bit j is the parity of the 7-bit window ANDed with generator j, and the generators are octal 133, 171 and 165. The window is {new input bit, state}. The state holds the six previous inputs, with the most recent in bit 5, so the next state is {input, state[5:1]}.
- R2: Opcode 0 (clear) zeroes all path metrics in one cycle. A following stage whose sample is all zero then returns all-zero decision words, because ties resolve to the predecessor whose state bit 0 is 0.
- R3: Opcode 1 consumes the sample and resolves states 0 to 31. Its response comes one cycle later, and bit i of the response is 1 when state i's survivor comes from predecessor {i[4:0],1}, i.e. that candidate's metric (predecessor metric plus correlation) is strictly larger.
- R4: Opcode 2 issued in the cycle right after opcode 1 resolves states 32 to 63 and returns their decision word one cycle later, with bit i belonging to state 32+i. Opcode 2 issued at any other time is ignored and produces no response.
- R5: Path metrics are 16 bits wide. After each completed stage they are renormalized by subtracting the minimum, so at least one metric is zero and none overflows.
- R6: Opcode 3 (traceback) takes the low and high decision words of one stage, starting from state 0 at the last stage. One cycle later `trace_bit` shows that stage's decoded bit, and the walk moves to the predecessor state.
- R7: Every 32nd traceback command after a clear raises `rsp_valid` one cycle later, carrying a word in which bit b is the decoded bit of frame position 32w+b. Words come out last word first. Other traceback commands and the clear command raise no response.
- R8: Frames whose length is a multiple of 32 and whose last six bits are zero decode without error under bounded noise and sparse sign errors.
- R9: After reset no response is pending, and a cycle with `cmd_valid` low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 clear, 1 lower update, 2 upper update, 3 traceback |
| cmd_sample | input | 32 | Three packed signed soft values |
| cmd_dec_lo | input | 32 | Traceback: decision word of states 0 to 31 |
| cmd_dec_hi | input | 32 | Traceback: decision word of states 32 to 63 |
| rsp_valid | output | 1 | Response word valid |
| rsp_data | output | 32 | Decision word or packed decoded word |
| trace_bit | output | 1 | Decoded bit of the latest traceback step |

## Verification
The hardest condition to reach from the ports is a full survivor memory that traces back correctly from state 0 while noise and wrong-sign symbols act on the metrics. Only a complete frame with a zero tail, fed through every stage and then walked backwards, exercises that path. The bench encodes random multi-word frames with bounded noise and sparse sign flips. It stores the returned decision words and feeds them back in reverse, and a scoreboard compares each emitted word with the original data. Tie handling and the lone upper-update command are reached directly after a clear, where the metrics are known.

// File: rtl/vit_pkg.sv
// Package: shared widths, opcodes and the code definition for the decoder.
// Assumes rate 1/3, constraint length 7; window = {input, state[5:0]}.
package vit_pkg;
    localparam int NCODE   = 3;
    localparam int SOFT_W  = 8;
    localparam int ST_W    = 6;
    localparam int NSTATE  = 1 << ST_W;
    localparam int HALF    = NSTATE / 2;
    localparam int NWORDS  = 1 << NCODE;
    localparam int PM_W    = 16;
    localparam int SUM_W   = PM_W + 1;
    localparam int BM_OFS  = NCODE * (1 << (SOFT_W - 1));
    localparam int BM_W    = $clog2(2 * BM_OFS + 1);
    localparam int WORD_W  = 32;

    typedef logic [PM_W-1:0]  pm_t;
    typedef logic [SUM_W-1:0] sum_t;
    typedef logic [BM_W-1:0]  bm_t;

    typedef enum logic [1:0] {
        OP_CLR    = 2'd0,
        OP_ACS_LO = 2'd1,
        OP_ACS_HI = 2'd2,
        OP_TRACE  = 2'd3
    } vit_op_e;

    localparam logic [ST_W:0] GEN_POLY [NCODE] = '{7'o133, 7'o171, 7'o165};

    // Coded bits for one 7-bit window.
    function automatic logic [NCODE-1:0] code_of(input logic [ST_W:0] win);
        logic [NCODE-1:0] c;
        for (int j = 0; j < NCODE; j++) c[j] = ^(win & GEN_POLY[j]);
        return c;
    endfunction
endpackage

// File: rtl/vit_bmu.sv
// Branch metric unit: correlation of the three soft values with every
// possible codeword, offset so that the result is never negative.
// Assumes a positive soft value means coded bit 1.
module vit_bmu
    import vit_pkg::*;
(
    input  logic [WORD_W-1:0] sample,
    output bm_t               bm [NWORDS]
);
    logic signed [BM_W+1:0] acc;
    logic signed [BM_W+1:0] xs;

    // Sum of +x or -x per component for every codeword.
    always_comb begin
        acc = '0;
        xs  = '0;
        for (int c = 0; c < NWORDS; c++) begin
            acc = (BM_W+2)'(BM_OFS);
            for (int j = 0; j < NCODE; j++) begin
                xs  = {{(BM_W+2-SOFT_W){sample[SOFT_W*j+SOFT_W-1]}}, sample[SOFT_W*j +: SOFT_W]};
                acc = c[j] ? acc + xs : acc - xs;
            end
            bm[c] = acc[BM_W-1:0];
        end
    end
endmodule

// File: rtl/vit_acs_half.sv
// Add-compare-select for one half of the trellis (32 next states).
// upper=0 resolves states 0..31, upper=1 states 32..63. The predecessors
// of next state {upper,i} are {i,0} and {i,1}; ties pick {i,0}.
module vit_acs_half
    import vit_pkg::*;
(
    input  pm_t              pm  [NSTATE],
    input  bm_t              bm  [NWORDS],
    input  logic             upper,
    output sum_t             sum [HALF],
    output logic [HALF-1:0]  dec
);
    for (genvar gi = 0; gi < HALF; gi++) begin : g_acs
        logic [NCODE-1:0] code0, code1;
        sum_t cand0, cand1;
        // Compare both candidate paths into this state and keep the larger.
        always_comb begin
            code0   = code_of({upper, (ST_W-1)'(gi), 1'b0});
            code1   = code_of({upper, (ST_W-1)'(gi), 1'b1});
            cand0   = SUM_W'(pm[2*gi])   + SUM_W'(bm[code0]);
            cand1   = SUM_W'(pm[2*gi+1]) + SUM_W'(bm[code1]);
            dec[gi] = cand1 > cand0;
            sum[gi] = (cand1 > cand0) ? cand1 : cand0;
        end
    end
endmodule

// File: rtl/vit_renorm.sv
// Renormalization: subtracts the minimum of the 64 new metrics and reports
// whether every result fits the stored metric width.
module vit_renorm
    import vit_pkg::*;
(
    input  sum_t  merged [NSTATE],
    output pm_t   pm_next [NSTATE],
    output logic  fits
);
    sum_t mn;
    sum_t diff;

    // Linear minimum search, then subtraction and width check.
    always_comb begin
        mn   = merged[0];
        diff = '0;
        fits = 1'b1;
        for (int i = 1; i < NSTATE; i++)
            if (merged[i] < mn) mn = merged[i];
        for (int i = 0; i < NSTATE; i++) begin
            diff       = merged[i] - mn;
            pm_next[i] = diff[PM_W-1:0];
            if (diff[SUM_W-1]) fits = 1'b0;
        end
    end
endmodule

// File: rtl/vit_traceback.sv
// Traceback walker: one stage per step, from the last stage to the first.
// Starts from state 0 after reset or clear; packs bits so that the first
// bit walked in a group ends in bit 31 of the emitted word.
module vit_traceback
    import vit_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               step,
    input  logic [HALF-1:0]    dec_lo,
    input  logic [HALF-1:0]    dec_hi,
    output logic               bit_q,
    output logic               word_valid,
    output logic [WORD_W-1:0]  word_q
);
    localparam int CNT_W = $clog2(WORD_W);

    logic [ST_W-1:0]   state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] acc_q;
    logic [NSTATE-1:0] dec_all;
    logic              cur_bit;

    assign dec_all = {dec_hi, dec_lo};
    assign cur_bit = state_q[ST_W-1];

    // Walk one stage back, shift the decoded bit in, emit every 32nd step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state_q    <= '0;
            cnt_q      <= '0;
            acc_q      <= '0;
            bit_q      <= 1'b0;
            word_valid <= 1'b0;
            word_q     <= '0;
        end else begin
            word_valid <= 1'b0;
            if (step) begin
                bit_q   <= cur_bit;
                state_q <= {state_q[ST_W-2:0], dec_all[state_q]};
                acc_q   <= {acc_q[WORD_W-2:0], cur_bit};
                cnt_q   <= cnt_q + 1'b1;
                if (cnt_q == CNT_W'(WORD_W-1)) begin
                    word_valid <= 1'b1;
                    word_q     <= {acc_q[WORD_W-2:0], cur_bit};
                end
            end
        end
    end

    // At least 32 steps separate two emitted words.
    assert_word_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);
endmodule

// File: rtl/vit_accel.sv
// Top of the Viterbi accelerator. Holds the 64 path metrics, splits each
// stage across two commands sharing one 32-wide ACS bank, and drives the
// traceback walker. Assumes the caller stores decision words and issues the
// upper update directly after the lower one.
module vit_accel
    import vit_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [31:0] cmd_sample,
    input  logic [31:0] cmd_dec_lo,
    input  logic [31:0] cmd_dec_hi,
    output logic        rsp_valid,
    output logic [31:0] rsp_data,
    output logic        trace_bit
);
    pm_t             pm_q     [NSTATE];
    sum_t            lo_q     [HALF];
    bm_t             bm_hold  [NWORDS];
    bm_t             bm_now   [NWORDS];
    bm_t             bm_use   [NWORDS];
    sum_t            acs_sum  [HALF];
    sum_t            merged   [NSTATE];
    pm_t             pm_next  [NSTATE];
    logic [HALF-1:0] acs_dec;
    logic            fits;
    logic            half_pend;
    logic            acs_v_q;
    logic [HALF-1:0] acs_d_q;
    logic            tb_v;
    logic [WORD_W-1:0] tb_word;

    logic do_clr, do_lo, do_hi, do_tb;
    assign do_clr = cmd_valid && (cmd_op == OP_CLR);
    assign do_lo  = cmd_valid && (cmd_op == OP_ACS_LO);
    assign do_hi  = cmd_valid && (cmd_op == OP_ACS_HI) && half_pend;
    assign do_tb  = cmd_valid && (cmd_op == OP_TRACE);

    vit_bmu u_bmu (.sample(cmd_sample), .bm(bm_now));

    // Upper half reuses the branch metrics captured with the lower half.
    always_comb begin
        for (int c = 0; c < NWORDS; c++) bm_use[c] = do_hi ? bm_hold[c] : bm_now[c];
    end

    vit_acs_half u_acs (.pm(pm_q), .bm(bm_use), .upper(do_hi), .sum(acs_sum), .dec(acs_dec));

    // Joins the staged lower half with the fresh upper half.
    always_comb begin
        for (int i = 0; i < HALF; i++) begin
            merged[i]        = lo_q[i];
            merged[HALF + i] = acs_sum[i];
        end
    end

    vit_renorm u_renorm (.merged(merged), .pm_next(pm_next), .fits(fits));

    // Path metric storage, lower-half staging and the decision response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSTATE; i++) pm_q[i] <= '0;
            for (int i = 0; i < HALF; i++) lo_q[i] <= '0;
            for (int c = 0; c < NWORDS; c++) bm_hold[c] <= '0;
            half_pend <= 1'b0;
            acs_v_q   <= 1'b0;
            acs_d_q   <= '0;
        end else begin
            half_pend <= do_lo;
            acs_v_q   <= do_lo || do_hi;
            if (do_lo || do_hi) acs_d_q <= acs_dec;
            if (do_clr) begin
                for (int i = 0; i < NSTATE; i++) pm_q[i] <= '0;
            end else if (do_hi) begin
                for (int i = 0; i < NSTATE; i++) pm_q[i] <= pm_next[i];
            end
            if (do_lo) begin
                for (int i = 0; i < HALF; i++) lo_q[i] <= acs_sum[i];
                for (int c = 0; c < NWORDS; c++) bm_hold[c] <= bm_now[c];
            end
        end
    end

    vit_traceback u_tb (
        .clk(clk), .rst_n(rst_n), .clr(do_clr), .step(do_tb),
        .dec_lo(cmd_dec_lo), .dec_hi(cmd_dec_hi),
        .bit_q(trace_bit), .word_valid(tb_v), .word_q(tb_word)
    );

    assign rsp_valid = acs_v_q || tb_v;
    assign rsp_data  = acs_v_q ? acs_d_q : tb_word;

    // Checker flags derived from the stored metrics.
    logic pm_all_zero, pm_has_zero;
    always_comb begin
        pm_all_zero = 1'b1;
        pm_has_zero = 1'b0;
        for (int i = 0; i < NSTATE; i++) begin
            if (pm_q[i] != '0) pm_all_zero = 1'b0;
            if (pm_q[i] == '0) pm_has_zero = 1'b1;
        end
    end

    assert_clr_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        do_clr |=> pm_all_zero);
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        do_hi |-> fits);
    assert_min_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        do_hi |=> pm_has_zero);
    assert_hi_after_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        do_hi |-> $past(cmd_valid && cmd_op == OP_ACS_LO));
    assert_single_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(acs_v_q && tb_v));
endmodule

// File: tb/vit_accel_tb_top.sv
module vit_accel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [31:0] cmd_sample = '0;
    logic [31:0] cmd_dec_lo = '0;
    logic [31:0] cmd_dec_hi = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        trace_bit;

    int checks = 0;
    int fails  = 0;
    bit tb_phase = 1'b0;
    logic [31:0] exp_q [$];
    logic [31:0] dlo [64];
    logic [31:0] dhi [64];

    localparam logic [6:0] G0 = 7'b1011011;
    localparam logic [6:0] G1 = 7'b1111001;
    localparam logic [6:0] G2 = 7'b1110101;

    always #2.5 clk = ~clk;

    vit_accel dut_i (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [1:0] op, input logic [31:0] s, input logic [31:0] lo, input logic [31:0] hi);
        cmd_valid = 1'b1; cmd_op = op; cmd_sample = s; cmd_dec_lo = lo; cmd_dec_hi = hi;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle();
        cmd_valid = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [2:0] enc(input logic [6:0] w);
        return {^(w & G2), ^(w & G1), ^(w & G0)};
    endfunction

    function automatic int corr(input logic [2:0] c, input logic [31:0] s);
        int a = 0;
        for (int j = 0; j < 3; j++) begin
            int x = $signed(s[8*j +: 8]);
            a += c[j] ? x : -x;
        end
        return a;
    endfunction

    // Scoreboard monitor: compares each emitted traceback word.
    always @(negedge clk) begin
        if (tb_phase && rsp_valid) begin
            logic [31:0] e;
            if (exp_q.size() == 0) check(1'b0, "R7 unexpected word", rsp_data, 32'h0);
            else begin
                e = exp_q.pop_front();
                check(rsp_data == e, "R8/R7 decoded word", rsp_data, e);
            end
        end
    end

    // Driver: encodes, feeds stages, then walks back; mode 1 noise, 2 noise+flips.
    task automatic run_frame(input int nwords, input int mode, input bit zero_data);
        logic [63:0] fb;
        logic [5:0] st;
        int nb = 32 * nwords;
        int bad_bit = 0;
        int bad_rsp = 0;
        int sym = 0;
        for (int k = 0; k < 64; k++) fb[k] = zero_data ? 1'b0 : 1'($urandom);
        for (int k = nb - 6; k < nb; k++) fb[k] = 1'b0;
        cmd(2'd0, 0, 0, 0);
        check(rsp_valid == 1'b0, "R7 clear gives no response", {31'b0, rsp_valid}, 0);
        st = '0;
        for (int k = 0; k < nb; k++) begin
            logic [2:0] c;
            logic [31:0] s;
            c = enc({fb[k], st});
            st = {fb[k], st[5:1]};
            s = '0;
            for (int j = 0; j < 3; j++) begin
                int v = c[j] ? 60 : -60;
                if (mode >= 1) v += int'($urandom % 81) - 40;
                if (mode == 2 && (sym % 13) == 5) v = c[j] ? -20 : 20;
                sym++;
                s[8*j +: 8] = 8'(v);
            end
            cmd(2'd1, s, 0, 0);
            dlo[k] = rsp_data;
            cmd(2'd2, 0, 0, 0);
            dhi[k] = rsp_data;
        end
        idle();
        for (int w = nwords - 1; w >= 0; w--) exp_q.push_back(fb[32*w +: 32]);
        tb_phase = 1'b1;
        for (int k = nb - 1; k >= 0; k--) begin
            cmd(2'd3, 0, dlo[k], dhi[k]);
            if (trace_bit != fb[k]) bad_bit++;
            if ((k % 32) != 0 && rsp_valid) bad_rsp++;
        end
        idle(); idle();
        tb_phase = 1'b0;
        check(bad_bit == 0, "R6 per-step decoded bits", bad_bit, 0);
        check(bad_rsp == 0, "R7 no response between words", bad_rsp, 0);
        check(exp_q.size() == 0, "R7 all words emitted", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] s, elo, ehi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R9 no response after reset", {31'b0, rsp_valid}, 0);
        idle();
        check(rsp_valid == 1'b0, "R9 idle cycle no response", {31'b0, rsp_valid}, 0);

        // R4: upper update without a lower one is ignored
        cmd(2'd0, 0, 0, 0);
        cmd(2'd2, 0, 0, 0);
        check(rsp_valid == 1'b0, "R4 lone upper update ignored", {31'b0, rsp_valid}, 0);

        // R1/R3/R4: first stage after clear, decisions from correlation only
        s = {8'h00, 8'hB0, 8'hD3, 8'h47};
        elo = '0; ehi = '0;
        for (int i = 0; i < 32; i++) begin
            elo[i] = corr(enc({1'b0, 5'(i), 1'b1}), s) > corr(enc({1'b0, 5'(i), 1'b0}), s);
            ehi[i] = corr(enc({1'b1, 5'(i), 1'b1}), s) > corr(enc({1'b1, 5'(i), 1'b0}), s);
        end
        cmd(2'd1, s, 0, 0);
        check(rsp_valid && rsp_data == elo, "R3 R1 lower decision word", rsp_data, elo);
        cmd(2'd2, 32'h5A5A5A5A, 0, 0);
        check(rsp_valid && rsp_data == ehi, "R4 R1 upper decision word", rsp_data, ehi);
        idle();
        check(rsp_valid == 1'b0, "R9 response lasts one cycle", {31'b0, rsp_valid}, 0);

        run_frame(1, 0, 1'b0);
        run_frame(2, 1, 1'b0);

        // R2: after a frame, clear then all-zero sample gives zero decisions
        cmd(2'd0, 0, 0, 0);
        cmd(2'd1, 0, 0, 0);
        check(rsp_data == 32'h0, "R2 tie lower word after clear", rsp_data, 0);
        cmd(2'd2, 0, 0, 0);
        check(rsp_data == 32'h0, "R2 tie upper word after clear", rsp_data, 0);
        idle();

        run_frame(2, 2, 1'b0);
        run_frame(1, 1, 1'b1);
        run_frame(2, 2, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule